// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block selects one interrupt out of 256 numbered sources and gives the CPU that interrupt's number and its vector address. The vector address is the interrupt number times two, which places every vector in the lowest 512 words of memory. Hardware sources drive a level request vector. Each number has its own mask bit. Software can also raise numbers 1 through 255, and the block holds those requests in an internal pending register until the matching routine is entered.

The block keeps a stack of the interrupt numbers that are now in service, so routines can nest. A lower number has higher priority, and number 0, the periodic timer tick, outranks every other source. A candidate is offered to the CPU only when its number is strictly below the number on top of the stack. The CPU pulses `isr_enter_i` to take the offered interrupt, which pushes it onto the stack. It pulses `isr_done_i` when the routine ends, which pops the stack. A request that is not yet eligible stays pending and is offered again later.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the in-service stack is empty, no software request is held, and `irq_pend_o` is low while no unmasked request is present.
- R2: `irq_vec_o` equals `irq_num_o` shifted left by one bit and zero-extended to 20 bits. Number 0x00 gives 0x00000 and number 0xFF gives 0x001FE.
- R3: A number whose `irq_mask_i` bit is 1 is never offered. This includes number 0.
- R4: Among the unmasked requests, the lowest number wins. When number 0 is requested and unmasked, it is always the one offered.
- R5: A pulse on `sw_req_i` with `sw_num_i` from 1 to 255 marks that number pending until that number is entered. A pulse with `sw_num_i` equal to 0 has no effect.
- R6: A software request and hardware requests that arrive in the same cycle are compared by number alone, and the software request counts as present in its own cycle.
- R7: `irq_pend_o` is high only when the winning number is strictly below the number on top of the in-service stack. An empty stack allows any number.
- R8: `isr_enter_i` while `irq_pend_o` is high pushes `irq_num_o` and clears that number's software pending bit. `isr_enter_i` while `irq_pend_o` is low is ignored. `isr_done_i` pops one entry and is ignored when the stack is empty. When both pulse in the same cycle, only the pop takes effect.
- R9: A request whose number is equal to or above the top of the stack is not lost. It is offered once the blocking routines have ended.
- R10: While the stack holds `STACK_DEPTH` (16) entries, `irq_pend_o` stays low until a pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_i | input | 256 | Level requests from hardware, one bit per number |
| irq_mask_i | input | 256 | Mask bits, 1 blocks that number |
| sw_req_i | input | 1 | Software raise pulse |
| sw_num_i | input | 8 | Number raised by software |
| isr_enter_i | input | 1 | CPU takes the offered interrupt (push) |
| isr_done_i | input | 1 | Current routine has ended (pop) |
| irq_pend_o | output | 1 | An eligible interrupt is offered |
| irq_num_o | output | 8 | Number of the winning interrupt |
| irq_vec_o | output | 20 | Vector address, number times two |

## Verification
The bench goes after these corner cases:
- A masked tick on number 0 while other requests are present. A design that ignores the mask on number 0 would offer the tick.
- A software raise of number 0. A design that lets software raise number 0 would offer it.
- Requests at the same number as the top of the stack. A design that allows equal-priority nesting would re-enter the running routine.
- Entry and end-of-routine pulsed in the same cycle. A design that handles both would push and pop at once and corrupt the stack.
- A stack filled to 16 entries. A design without the full check would drop the deepest return level.
- The number 0xFF. A vector computation that truncates would fail at 0x001FE.

// File: rtl/irq_pkg.sv
// Package irq_pkg: default sizes shared by the interrupt controller modules.
// Assumes the number of sources is a power of two.
package irq_pkg;
    localparam int unsigned IRQ_COUNT   = 256;
    localparam int unsigned IRQ_STACK   = 16;
    localparam int unsigned IRQ_ADDR_W  = 20;
endpackage

// File: rtl/irq_pick.sv
// irq_pick: finds the lowest-numbered set bit of a request vector.
// Assumes N is a power of two; any_o is low when no bit is set.
module irq_pick #(
    parameter int unsigned N  = irq_pkg::IRQ_COUNT,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // scan from the top down so the lowest set index is written last
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_stack.sv
// irq_stack: LIFO of in-service priority levels.
// top_o is IDLE_LVL when the stack is empty. pop wins over push, and a push
// into a full stack is dropped. The caller keeps pushes away from a full stack.
module irq_stack #(
    parameter int unsigned DEPTH    = irq_pkg::IRQ_STACK,
    parameter int unsigned LW       = 9,
    parameter int unsigned IDLE_LVL = 256,
    localparam int unsigned PW      = $clog2(DEPTH + 1),
    localparam int unsigned IW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] push_lvl_i,
    output logic [LW-1:0] top_o,
    output logic          full_o
);
    logic [LW-1:0] mem [DEPTH];
    logic [PW-1:0] cnt_q;
    logic          empty;
    logic          do_pop;
    logic          do_push;

    assign empty   = (cnt_q == '0);
    assign full_o  = (cnt_q == PW'(DEPTH));
    assign do_pop  = pop_i && !empty;
    assign do_push = push_i && !pop_i && !full_o;

    // occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (do_pop)  cnt_q <= cnt_q - 1'b1;
        else if (do_push) cnt_q <= cnt_q + 1'b1;
    end

    // entry storage, written at the current fill level
    always_ff @(posedge clk) begin
        if (do_push) mem[IW'(cnt_q)] <= push_lvl_i;
    end

    // level of the innermost running routine
    always_comb begin
        if (empty) top_o = LW'(IDLE_LVL);
        else       top_o = mem[IW'(cnt_q - 1'b1)];
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// irq_prio_ctrl: prioritized vectored interrupt controller with nesting.
// Lower number = higher priority, so number 0 (timer tick) is highest.
// Hardware requests are levels. Software raises are held until entered.
// The outputs are combinational from the inputs and the registered state.
module irq_prio_ctrl #(
    parameter int unsigned NUM_IRQ     = irq_pkg::IRQ_COUNT,
    parameter int unsigned STACK_DEPTH = irq_pkg::IRQ_STACK,
    parameter int unsigned ADDR_W      = irq_pkg::IRQ_ADDR_W,
    localparam int unsigned NW         = $clog2(NUM_IRQ),
    localparam int unsigned LW         = NW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic [NUM_IRQ-1:0] irq_mask_i,
    input  logic               sw_req_i,
    input  logic [NW-1:0]      sw_num_i,
    input  logic               isr_enter_i,
    input  logic               isr_done_i,
    output logic               irq_pend_o,
    output logic [NW-1:0]      irq_num_o,
    output logic [ADDR_W-1:0]  irq_vec_o
);
    logic [NUM_IRQ-1:0] sw_pend_q;
    logic [NUM_IRQ-1:0] sw_now;
    logic [NUM_IRQ-1:0] cand;
    logic               any_cand;
    logic [NW-1:0]      win;
    logic [LW-1:0]      top_lvl;
    logic               stk_full;
    logic               take;

    // one-hot of this cycle's software raise; number 0 cannot be raised
    always_comb begin
        sw_now = '0;
        if (sw_req_i && (sw_num_i != '0)) sw_now[sw_num_i] = 1'b1;
    end

    // eligible sources: hardware, held software and new software, unmasked
    assign cand = (irq_req_i | sw_pend_q | sw_now) & ~irq_mask_i;

    irq_pick #(.N(NUM_IRQ)) u_pick (
        .cand_i (cand),
        .any_o  (any_cand),
        .idx_o  (win)
    );

    irq_stack #(
        .DEPTH    (STACK_DEPTH),
        .LW       (LW),
        .IDLE_LVL (NUM_IRQ)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .pop_i      (isr_done_i),
        .push_lvl_i ({1'b0, win}),
        .top_o      (top_lvl),
        .full_o     (stk_full)
    );

    // offer only a strictly higher priority than the running routine
    assign irq_pend_o = any_cand && ({1'b0, win} < top_lvl) && !stk_full;
    assign irq_num_o  = win;
    assign irq_vec_o  = {{(ADDR_W - NW - 1){1'b0}}, win, 1'b0};
    assign take       = isr_enter_i && irq_pend_o && !isr_done_i;

    // per-number software pending bits: set by a raise, cleared on entry
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_swp
        always_ff @(posedge clk) begin
            if (!rst_n)
                sw_pend_q[g] <= 1'b0;
            else if (take && (win == NW'(g)))
                sw_pend_q[g] <= 1'b0;
            else if (sw_now[g])
                sw_pend_q[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_chk.sv
// irq_prio_chk: property checks on the controller ports, attached by bind.
module irq_prio_chk #(
    parameter int unsigned NUM_IRQ = irq_pkg::IRQ_COUNT,
    parameter int unsigned ADDR_W  = irq_pkg::IRQ_ADDR_W,
    localparam int unsigned NW     = $clog2(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_req_i,
    input logic [NUM_IRQ-1:0] irq_mask_i,
    input logic               isr_enter_i,
    input logic               isr_done_i,
    input logic               irq_pend_o,
    input logic [NW-1:0]      irq_num_o,
    input logic [ADDR_W-1:0]  irq_vec_o
);
    // R2
    vec_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend_o |-> (irq_vec_o == ADDR_W'({irq_num_o, 1'b0})));

    // R3
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend_o |-> !irq_mask_i[irq_num_o]);

    // R4
    tick_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && irq_req_i[0] && !irq_mask_i[0]) |-> (irq_num_o == '0));

    // R5
    sw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && irq_num_o == '0) |-> irq_req_i[0]);

    // R7
    nest_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && isr_enter_i && !isr_done_i) |=>
            (!irq_pend_o || (irq_num_o < $past(irq_num_o))));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req_i   (irq_req_i),
    .irq_mask_i  (irq_mask_i),
    .isr_enter_i (isr_enter_i),
    .isr_done_i  (isr_done_i),
    .irq_pend_o  (irq_pend_o),
    .irq_num_o   (irq_num_o),
    .irq_vec_o   (irq_vec_o)
);

// File: tb/sim_irq_prio_ctrl.sv
// sim_irq_prio_ctrl: directed corner cases plus seeded random traffic,
// compared every cycle against a bench model of the requirements.
module sim_irq_prio_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] req = '0;
    logic [255:0] mask = '0;
    logic         sw_req = 1'b0;
    logic [7:0]   sw_num = '0;
    logic         enter = 1'b0;
    logic         done = 1'b0;
    logic         pend;
    logic [7:0]   num;
    logic [19:0]  vec;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit [255:0] m_swp;
    int         m_stk[$];
    bit         e_pend;
    int         e_win;

    always #10 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .irq_mask_i(mask),
        .sw_req_i(sw_req), .sw_num_i(sw_num), .isr_enter_i(enter),
        .isr_done_i(done), .irq_pend_o(pend), .irq_num_o(num), .irq_vec_o(vec)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // expected offer from the requirements
    function automatic void predict();
        bit [255:0] eff = req | m_swp;
        int top = (m_stk.size() == 0) ? 256 : m_stk[m_stk.size() - 1];
        if (sw_req && sw_num != 0) eff[sw_num] = 1'b1;
        eff &= ~mask;
        e_win = -1;
        for (int i = 255; i >= 0; i--) if (eff[i]) e_win = i;
        e_pend = (e_win >= 0) && (e_win < top) && (m_stk.size() < 16);
    endfunction

    // check current outputs, advance model, wait one cycle, clear pulses
    task automatic cycle(input string tag);
        #1;
        predict();
        chk({tag, " pend"}, int'(pend), int'(e_pend));
        if (e_pend) begin
            chk({tag, " num"}, int'(num), e_win);
            chk("R2 vec", int'(vec), e_win * 2);
        end
        if (sw_req && sw_num != 0) m_swp[sw_num] = 1'b1;
        if (done) begin
            if (m_stk.size() > 0) void'(m_stk.pop_back());
        end else if (enter && e_pend) begin
            m_stk.push_back(e_win);
            m_swp[e_win] = 1'b0;
        end
        @(negedge clk);
        sw_req = 1'b0; enter = 1'b0; done = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_swp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        cycle("R1");
        req[40] = 1'b1; cycle("R1");
        // R4: tick beats every other number; R2 vector of 0
        req[0] = 1'b1; req[3] = 1'b1; cycle("R4");
        chk("R2 vec0", int'(vec), 0);
        // R3: masked tick gives way to 3
        mask[0] = 1'b1; cycle("R3");
        mask[3] = 1'b1; mask[40] = 1'b1; cycle("R3");
        req = '0; mask = '0;
        // R2: highest number
        req[255] = 1'b1; #1; chk("R2 vecFF", int'(vec), 32'h1FE); cycle("R2");
        req = '0;
        // R5: software number 0 ignored, number 9 held
        sw_req = 1'b1; sw_num = 8'd0; cycle("R5");
        cycle("R5");
        sw_req = 1'b1; sw_num = 8'd9; cycle("R5");
        cycle("R5");
        // R6: same-cycle software 7 vs hardware 8, then hardware 6
        req[8] = 1'b1; sw_req = 1'b1; sw_num = 8'd7; cycle("R6");
        req[6] = 1'b1; sw_req = 1'b1; sw_num = 8'd20; cycle("R6");
        // R8: enter 6, then same-priority and lower stay blocked (R7, R9)
        enter = 1'b1; cycle("R8");
        cycle("R7");
        req[6] = 1'b0; cycle("R9");
        req[5] = 1'b1; cycle("R7");
        req[5] = 1'b0;
        // R8: enter and done together -> pop only
        enter = 1'b1; done = 1'b1; cycle("R8");
        cycle("R9");
        // take 7 (software), check its bit cleared after done
        enter = 1'b1; cycle("R8");
        done = 1'b1; cycle("R9");
        cycle("R5");
        // R8: done on empty and enter without pend are ignored
        req = '0; m_swp = m_swp; 
        while (m_stk.size() > 0) begin done = 1'b1; cycle("R8"); end
        // drain remaining software requests
        for (int k = 0; k < 8; k++) begin enter = 1'b1; cycle("R8"); done = 1'b1; cycle("R8"); end
        done = 1'b1; cycle("R8");
        enter = 1'b1; cycle("R8");
        // R10: fill the stack with 255 down to 240, then tick is blocked
        for (int k = 255; k >= 240; k--) begin
            req[k] = 1'b1; enter = 1'b1; cycle("R10");
        end
        req[0] = 1'b1; cycle("R10");
        cycle("R10");
        done = 1'b1; cycle("R10");
        cycle("R10");
        req = '0;
        while (m_stk.size() > 0) begin done = 1'b1; cycle("R8"); end
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            req = '0; mask = '0;
            for (int j = 0; j < 3; j++) if ($urandom_range(0, 1)) req[$urandom_range(0, 255)] = 1'b1;
            if ($urandom_range(0, 15) == 0) req[0] = 1'b1;
            for (int j = 0; j < 2; j++) if ($urandom_range(0, 2) == 0) mask[$urandom_range(0, 255)] = 1'b1;
            if ($urandom_range(0, 7) == 0) begin sw_req = 1'b1; sw_num = 8'($urandom_range(0, 255)); end
            enter = ($urandom_range(0, 2) == 0);
            done  = ($urandom_range(0, 3) == 0);
            cycle("R4");
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule